// File: doc/BRIEF.md
# Console Register Controller

This block is the register front end of a simple console device. A processor reaches it over a 32-bit register bus: a write enable, a byte offset and write data, plus a combinational read-data return for the offset currently presented. Received characters come in on a byte stream with a valid/ready handshake and are held in a receive FIFO. Each write to the character register sends a single byte out on a transmit stream that carries a one-cycle valid.

For block moves the controller holds a 64-bit buffer address and a 32-bit length. It passes them to a separate transfer engine, together with a start pulse and a direction. The engine can also drain the receive FIFO through a pop port. A level interrupt tells the processor that received data is waiting, but only while interrupts are enabled.

Commands go through a two-state sequencer. In `CS_IDLE` the block is ready to accept a start command. The **launch** transition moves it from `CS_IDLE` to `CS_ISSUE`; it fires when a start command arrives and the engine is not busy. In `CS_ISSUE` the start pulse is driven for exactly one cycle. The **retire** transition then always returns the sequencer to `CS_IDLE`.

Top module: `con_regif`

## Requirements
- R1: After reset the FIFO is empty, rx_ready is 1, irq is 0, buf_ptr and buf_len are 0, and interrupts are disabled.
- R2: A read of offset 0x04 returns the number of bytes held in the FIFO, zero-extended to 32 bits. Each accepted byte raises that number by one.
- R3: A read of offset 0x20 returns 1. A read of any other offset returns 0, including the write-only offsets 0x00, 0x08, 0x10, 0x14 and 0x18 and every offset at or above 0x24.
- R4: A write to offset 0x00 drives tx_valid high for exactly the next cycle, with tx_data equal to bits 7:0 of the write data.
- R5: A write to 0x10 loads the whole 64-bit buf_ptr with the zero-extended write data. A write to 0x18 replaces bits 63:32 of buf_ptr and leaves bits 31:0 unchanged. A write to 0x14 loads buf_len.
- R6: irq is high exactly while interrupts are enabled and the FIFO holds at least one byte. Writing command value 0 to offset 0x08 disables interrupts; writing value 1 enables them.
- R7: rx_ready is high exactly while the FIFO has a free entry. A byte offered while rx_ready is low is not stored.
- R8: Writing command value 2 starts a memory-to-transmit move and value 3 starts a receive-to-memory move. In the cycle after the write, xfer_start is high for one cycle, with xfer_dir 0 for value 2 and 1 for value 3.
- R9: A start command is dropped when xfer_busy is high or the sequencer is in CS_ISSUE. Command values above 3 have no effect.
- R10: drain_data shows the oldest stored byte. drain_pop removes it, so bytes leave the FIFO in arrival order. Draining the last byte drops irq.
- R11: Writes to offsets outside the decoded set (for example 0x0C or 0x24) change no output and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO has a free entry |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_dir | output | 1 | 0 = memory to transmit, 1 = receive to memory |
| xfer_busy | input | 1 | Transfer engine is busy |
| buf_ptr | output | 64 | Buffer address for the transfer |
| buf_len | output | 32 | Buffer length for the transfer |
| drain_pop | input | 1 | Remove the oldest FIFO byte |
| drain_data | output | 8 | Oldest FIFO byte |
| drain_valid | output | 1 | FIFO is not empty |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check, on every cycle, the relationships between a bus write and the effect it has one cycle later:
- the transmit echo and the absence of stray tx strobes;
- the interrupt dropping after a disable command and rising after a byte is received;
- the FIFO count growing on an accepted byte and holding when a byte is refused;
- the one-cycle width of the start pulse and the busy drop;
- the partial update of the high pointer word;
- the constant value read from the version offset.

Only the bench scenarios can show arrival-order draining across a full FIFO, the loss of a byte offered while the FIFO is full, the full-width reload of the pointer, and the drop of a second start written while the first pulse is still out. They also show that unmapped writes leave every register untouched.

// File: rtl/con_pkg.sv
package con_pkg;

    localparam logic [7:0] OFS_TXCHAR = 8'h00;
    localparam logic [7:0] OFS_AVAIL  = 8'h04;
    localparam logic [7:0] OFS_CMD    = 8'h08;
    localparam logic [7:0] OFS_PTR_LO = 8'h10;
    localparam logic [7:0] OFS_LEN    = 8'h14;
    localparam logic [7:0] OFS_PTR_HI = 8'h18;
    localparam logic [7:0] OFS_ID     = 8'h20;

    localparam logic [31:0] ID_VALUE = 32'd1;

    localparam logic [31:0] CMD_IRQ_OFF = 32'd0;
    localparam logic [31:0] CMD_IRQ_ON  = 32'd1;
    localparam logic [31:0] CMD_MEM2TX  = 32'd2;
    localparam logic [31:0] CMD_RX2MEM  = 32'd3;

    typedef enum logic {
        CS_IDLE  = 1'b0,
        CS_ISSUE = 1'b1
    } cmd_state_e;

    typedef enum logic {
        DIR_MEM_TO_TX = 1'b0,
        DIR_RX_TO_MEM = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/con_rx_fifo.sv
module con_rx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [CNT_W-1:0]  fill
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              do_push;
    logic              do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (cnt != CNT_W'(DEPTH));
    assign pop_valid  = (cnt != '0);
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop_req && pop_valid;
    assign pop_data   = store[rd_ptr];
    assign fill       = cnt;

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/con_cmd_ctl.sv
module con_cmd_ctl
    import con_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_code,
    input  logic        xfer_busy,
    output logic        irq_en,
    output logic        xfer_start,
    output logic        xfer_dir
);

    cmd_state_e state_q;
    cmd_state_e state_d;
    xfer_dir_e  dir_q;
    logic       start_req;
    logic       launch;

    assign start_req = cmd_we && ((cmd_code == CMD_MEM2TX) || (cmd_code == CMD_RX2MEM));

    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                if (start_req && !xfer_busy) begin
                    state_d = CS_ISSUE;
                    launch  = 1'b1;
                end
            end
            CS_ISSUE: begin
                state_d = CS_IDLE;
            end
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            dir_q   <= DIR_MEM_TO_TX;
            irq_en  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                dir_q <= (cmd_code == CMD_RX2MEM) ? DIR_RX_TO_MEM : DIR_MEM_TO_TX;
            end
            if (cmd_we && (cmd_code == CMD_IRQ_OFF)) begin
                irq_en <= 1'b0;
            end else if (cmd_we && (cmd_code == CMD_IRQ_ON)) begin
                irq_en <= 1'b1;
            end
        end
    end

    always_comb begin
        xfer_start = 1'b0;
        xfer_dir   = dir_q;
        unique case (state_q)
            CS_IDLE:  xfer_start = 1'b0;
            CS_ISSUE: xfer_start = 1'b1;
            default:  xfer_start = 1'b0;
        endcase
    end

endmodule

// File: rtl/con_reg_bank.sv
module con_reg_bank
    import con_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [CNT_W-1:0]  fill,
    output logic [31:0]       bus_rdata,
    output logic              cmd_we,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic [63:0]       buf_ptr,
    output logic [31:0]       buf_len
);

    logic hit_tx;
    logic hit_lo;
    logic hit_hi;
    logic hit_len;

    assign hit_tx  = bus_we && (bus_addr == ADDR_W'(OFS_TXCHAR));
    assign hit_lo  = bus_we && (bus_addr == ADDR_W'(OFS_PTR_LO));
    assign hit_hi  = bus_we && (bus_addr == ADDR_W'(OFS_PTR_HI));
    assign hit_len = bus_we && (bus_addr == ADDR_W'(OFS_LEN));
    assign cmd_we  = bus_we && (bus_addr == ADDR_W'(OFS_CMD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            buf_ptr  <= '0;
            buf_len  <= '0;
        end else begin
            tx_valid <= hit_tx;
            if (hit_tx) begin
                tx_data <= bus_wdata[7:0];
            end
            if (hit_lo) begin
                buf_ptr <= {32'd0, bus_wdata};
            end else if (hit_hi) begin
                buf_ptr <= {bus_wdata, buf_ptr[31:0]};
            end
            if (hit_len) begin
                buf_len <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_AVAIL)) begin
            bus_rdata = 32'(fill);
        end else if (bus_addr == ADDR_W'(OFS_ID)) begin
            bus_rdata = ID_VALUE;
        end
    end

endmodule

// File: rtl/con_regif.sv
module con_regif #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              xfer_start,
    output logic              xfer_dir,
    input  logic              xfer_busy,
    output logic [63:0]       buf_ptr,
    output logic [31:0]       buf_len,
    input  logic              drain_pop,
    output logic [7:0]        drain_data,
    output logic              drain_valid,
    output logic              irq
);

    logic [CNT_W-1:0] fill;
    logic             cmd_we;
    logic             irq_en;

    con_rx_fifo #(.DEPTH(DEPTH), .DATA_W(8)) rx_fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (rx_valid),
        .push_data  (rx_data),
        .push_ready (rx_ready),
        .pop_req    (drain_pop),
        .pop_data   (drain_data),
        .pop_valid  (drain_valid),
        .fill       (fill)
    );

    con_reg_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) reg_bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .fill      (fill),
        .bus_rdata (bus_rdata),
        .cmd_we    (cmd_we),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .buf_ptr   (buf_ptr),
        .buf_len   (buf_len)
    );

    con_cmd_ctl cmd_ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_code   (bus_wdata),
        .xfer_busy  (xfer_busy),
        .irq_en     (irq_en),
        .xfer_start (xfer_start),
        .xfer_dir   (xfer_dir)
    );

    assign irq = irq_en && drain_valid;

endmodule

// File: rtl/con_regif_chk.sv
module con_regif_chk
    import con_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              xfer_start,
    input logic              xfer_busy,
    input logic [63:0]       buf_ptr,
    input logic              drain_pop,
    input logic              irq,
    input logic              irq_en,
    input logic [CNT_W-1:0]  fill
);

    logic wr_tx;
    logic wr_cmd;
    logic wr_hi;

    assign wr_tx  = bus_we && (bus_addr == ADDR_W'(OFS_TXCHAR));
    assign wr_cmd = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_hi  = bus_we && (bus_addr == ADDR_W'(OFS_PTR_HI));

    AST_TX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> (tx_valid && (tx_data == $past(bus_wdata[7:0])))); // R4
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tx |=> !tx_valid); // R11
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && (bus_wdata == CMD_IRQ_OFF)) |=> !irq); // R6
    AST_IRQ_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && rx_valid && rx_ready && !wr_cmd) |=> irq); // R6
    AST_FILL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !drain_pop) |=> (fill == CNT_W'($past(fill) + 1'b1))); // R2
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !drain_pop) |=> (fill == $past(fill))); // R7
    AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R8
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && xfer_busy && ((bus_wdata == CMD_MEM2TX) || (bus_wdata == CMD_RX2MEM)))
        |=> !xfer_start); // R9
    AST_PTR_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> ((buf_ptr[31:0] == $past(buf_ptr[31:0])) && (buf_ptr[63:32] == $past(bus_wdata)))); // R5
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_ID)) |-> (bus_rdata == ID_VALUE)); // R3

endmodule

bind con_regif con_regif_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .xfer_start (xfer_start),
    .xfer_busy  (xfer_busy),
    .buf_ptr    (buf_ptr),
    .drain_pop  (drain_pop),
    .irq        (irq),
    .irq_en     (irq_en),
    .fill       (fill)
);

// File: tb/con_regif_tb_top.sv
module con_regif_tb_top;

    localparam int  ADDR_W = 8;
    localparam int  DEPTH  = 16;
    localparam time CLK_P  = 5ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              xfer_start;
    logic              xfer_dir;
    logic              xfer_busy = 1'b0;
    logic [63:0]       buf_ptr;
    logic [31:0]       buf_len;
    logic              drain_pop = 1'b0;
    logic [7:0]        drain_data;
    logic              drain_valid;
    logic              irq;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [7:0] tx_q[$];
    logic       st_q[$];

    always #(CLK_P / 2) clk = ~clk;

    con_regif #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
        .xfer_busy(xfer_busy), .buf_ptr(buf_ptr), .buf_len(buf_len),
        .drain_pop(drain_pop), .drain_data(drain_data),
        .drain_valid(drain_valid), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic put_char(input logic [31:0] d);
        tx_q.push_back(d[7:0]);
        wr(8'h00, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(req, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [7:0] exp);
        @(posedge clk); #1;
        drain_pop = 1'b1;
        @(negedge clk);
        chk(req, 64'(drain_data), 64'(exp));
        @(posedge clk); #1;
        drain_pop = 1'b0;
    endtask

    // monitor: scoreboard for the transmit strobe and the start pulse
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (tx_q.size() == 0) begin
                chk("R11 unexpected tx byte", 64'(tx_data), 64'hx);
            end else begin
                chk("R4 tx byte", 64'(tx_data), 64'(tx_q.pop_front()));
            end
        end
        if (rst_n && xfer_start) begin
            if (st_q.size() == 0) begin
                chk("R9 unexpected start", 64'(xfer_dir), 64'hx);
            end else begin
                chk("R8 start dir", 64'(xfer_dir), 64'(st_q.pop_front()));
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 rx_ready", 64'(rx_ready), 64'd1);
        chk("R1 buf_ptr", buf_ptr, 64'd0);
        chk("R1 buf_len", 64'(buf_len), 64'd0);
        rd_chk("R1 R2 count after reset", 8'h04, 32'd0);

        // R3 read map
        rd_chk("R3 id", 8'h20, 32'd1);
        rd_chk("R3 tx offset reads 0", 8'h00, 32'd0);
        rd_chk("R3 cmd offset reads 0", 8'h08, 32'd0);
        rd_chk("R3 ptr_hi offset reads 0", 8'h18, 32'd0);
        rd_chk("R3 beyond window", 8'h2C, 32'd0);

        // R4 transmit
        put_char(32'h1234_56A5);
        put_char(32'h0000_003C);
        repeat (2) @(posedge clk);

        // R5 pointer and length
        wr(8'h10, 32'hDEAD_BEEF);
        chk("R5 ptr lo", buf_ptr, 64'h0000_0000_DEAD_BEEF);
        wr(8'h18, 32'h1234_5678);
        chk("R5 ptr hi", buf_ptr, 64'h1234_5678_DEAD_BEEF);
        wr(8'h14, 32'd100);
        chk("R5 len", 64'(buf_len), 64'd100);
        wr(8'h10, 32'h0000_0011);
        chk("R5 ptr lo full reload", buf_ptr, 64'h0000_0000_0000_0011);

        // R11 unmapped writes
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0000_0001);
        @(negedge clk);
        chk("R11 ptr kept", buf_ptr, 64'h0000_0000_0000_0011);
        chk("R11 len kept", 64'(buf_len), 64'd100);
        chk("R11 irq kept", 64'(irq), 64'd0);
        rd_chk("R11 count kept", 8'h04, 32'd0);

        // R2 and R6: receive with the interrupt disabled, then toggle
        rx_push(8'h61);
        rx_push(8'h62);
        rx_push(8'h63);
        chk("R6 irq while disabled", 64'(irq), 64'd0);
        rd_chk("R2 count 3", 8'h04, 32'd3);
        wr(8'h08, 32'd1);
        chk("R6 irq after enable", 64'(irq), 64'd1);
        wr(8'h08, 32'd0);
        chk("R6 irq after disable", 64'(irq), 64'd0);
        wr(8'h08, 32'd1);
        chk("R6 irq re-enable", 64'(irq), 64'd1);

        // R10 drain order
        pop_chk("R10 first", 8'h61);
        pop_chk("R10 second", 8'h62);
        chk("R10 irq while one left", 64'(irq), 64'd1);
        pop_chk("R10 third", 8'h63);
        chk("R10 irq after drain", 64'(irq), 64'd0);
        rd_chk("R2 count 0", 8'h04, 32'd0);

        // R7 fill to full and overflow
        for (int i = 0; i < DEPTH; i++) begin
            rx_push(8'(8'h40 + i));
        end
        chk("R7 rx_ready full", 64'(rx_ready), 64'd0);
        chk("R6 irq full", 64'(irq), 64'd1);
        rx_push(8'hEE);
        rd_chk("R7 count stays full", 8'h04, 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            pop_chk("R10 R7 order after overflow", 8'(8'h40 + i));
        end
        chk("R7 rx_ready after drain", 64'(rx_ready), 64'd1);
        chk("R10 irq empty", 64'(irq), 64'd0);

        // R8 start commands
        st_q.push_back(1'b0);
        wr(8'h08, 32'd2);
        repeat (2) @(posedge clk);
        st_q.push_back(1'b1);
        wr(8'h08, 32'd3);
        repeat (2) @(posedge clk);

        // R9 ignored codes and busy drop
        wr(8'h08, 32'd5);
        wr(8'h08, 32'h0000_0102);
        xfer_busy = 1'b1;
        wr(8'h08, 32'd2);
        wr(8'h08, 32'd3);
        @(negedge clk);
        chk("R9 no start while busy", 64'(xfer_start), 64'd0);
        xfer_busy = 1'b0;
        chk("R9 irq unchanged by code 5", 64'(irq), 64'd0);

        // R9 back-to-back start: second is dropped in CS_ISSUE
        st_q.push_back(1'b0);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd2;
        @(posedge clk); #1;
        bus_wdata = 32'd3;
        @(posedge clk); #1;
        bus_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);

        chk("R4 tx queue drained", 64'(tx_q.size()), 64'd0);
        chk("R8 start queue drained", 64'(st_q.size()), 64'd0);
        done = 1'b1;
        summary();
    end

endmodule